// File: doc/BRIEF.md
# Camera Output Timing Generator

This block produces the frame and line timing for an 8-bit, two-bytes-per-pixel camera output stream. It runs on the data clock and keeps a column counter and a line counter. From them it drives an active-low vertical sync, a horizontal sync, a strobe that marks each active byte, and the pixel, line and byte-slot indices that a downstream pattern or pixel source uses to fill the active window. When the strobe is low it also supplies the fill byte for that slot: a chroma slot carries 0x80 and a luma slot carries 0x00.

The picture size is chosen by a 3-bit code. Codes 0 to 3 run in the normal operation mode, with a long frame. Codes 4 to 7 are the reduced, low-power sizes, with a frame of about half that length. The horizontal sync has two styles. In the fixed-pulse style it is low for a set number of clocks at the start of every line. In the data-qualifying style it is high only while active bytes are being sent. A new size or style waits for the end of the current frame before it takes effect.

After reset, and again after a wake pulse, the first few active lines are masked, so that no partial picture reaches the output.

Top module: `cam_sync_gen`

## Requirements
- R1: Each line lasts LINE_CLKS clocks (default 1560). In the fixed-pulse style (cfg_hs_blank=0) hsync is low for columns 0 to HS_LOW-1 (default 156) of every line and high for the rest of the line.
- R2: A frame lasts LINES_NORM lines (default 507) when the size code is 0 to 3, and LINES_LP lines (default 254) when the code is 4 to 7 (code bit 2 set). vsync is low during the first VS_LINES lines of each frame and high for the rest of the frame.
- R3: The size code selects pixels and lines as follows: 0=640x480, 1=352x288, 2=320x240, 3=176x144, 4=320x240, 5=176x144, 6=160x120, 7=128x96. A full frame therefore holds 2×pixels×lines active bytes on that many lines.
- R4: byte_en is high exactly in columns H_FIRST to H_FIRST+2×pixels−1 of lines V_FIRST to V_FIRST+lines−1. The active lines follow one another with no gap. The design requires H_FIRST ≥ HS_LOW.
- R5: In the data-qualifying style (cfg_hs_blank=1), hsync equals byte_en: it is high for two clocks per active pixel and low on every other clock.
- R6: While byte_en is low, fill_byte is 0x80 on even columns (chroma slot, byte_sel=0) and 0x00 on odd columns (luma slot, byte_sel=1). While byte_en is high, fill_byte is 0x00.
- R7: byte_sel equals bit 0 of the column. pix_x gives the pixel index (column − H_FIRST) / 2 while byte_en is high and is 0 otherwise. line_y gives line − V_FIRST on active lines and is 0 otherwise.
- R8: After reset, the first MASK_LINES active lines (default 4) carry no active bytes. On those lines byte_en stays low, and in the data-qualifying style hsync stays low as well.
- R9: A one-clock wake pulse reloads the mask. The next MASK_LINES active lines that end after the pulse carry no active bytes.
- R10: cfg_size and cfg_hs_blank are sampled only on the last clock of a frame, and during reset. A change made in the middle of a frame leaves the rest of that frame unchanged.
- R11: All outputs are registered and show the counter position one clock late. During reset the outputs read vsync=1, hsync=0, byte_en=0, fill_byte=0x80, byte_sel=0, pix_x=0, line_y=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 3 | Picture size code (R3) |
| cfg_hs_blank | input | 1 | 1 = data-qualifying hsync, 0 = fixed low pulse |
| wake | input | 1 | One-clock pulse that reloads the start-up mask |
| vsync | output | 1 | Vertical sync, active low |
| hsync | output | 1 | Horizontal sync in the selected style |
| byte_en | output | 1 | High on each active output byte |
| fill_byte | output | 8 | Blanking byte for the current slot |
| byte_sel | output | 1 | 0 = chroma slot, 1 = luma slot |
| pix_x | output | clog2(LINE_CLKS) | Pixel index within the active line |
| line_y | output | clog2(max frame lines) | Line index within the active window |

## Verification
Each output is due exactly one clock after the counter position it describes. The bench runs its own position model, advances it on the same clock edges as the design, and compares every output against that model at the falling edge that follows. Configuration and wake inputs are changed on the falling edge, so the model and the design sample them on the same rising edge. Frame-level totals are counted from one vsync fall to the next: clocks, active bytes, strobe bursts and hsync rises. A configuration change, a wake pulse or a reset is therefore judged over the whole frame in which its effect is due.

// File: rtl/cam_sync_pkg.sv
package cam_sync_pkg;
  localparam int NUM_SIZES = 8;
  localparam int SIZE_W    = 3;

  // Codes with the top bit set run the shorter low-power frame.
  typedef enum logic [SIZE_W-1:0] {
    SZ_640X480    = 3'd0,
    SZ_352X288    = 3'd1,
    SZ_320X240_NM = 3'd2,
    SZ_176X144_NM = 3'd3,
    SZ_320X240_LP = 3'd4,
    SZ_176X144_LP = 3'd5,
    SZ_160X120_LP = 3'd6,
    SZ_128X96_LP  = 3'd7
  } size_code_e;

  localparam logic [7:0] CHROMA_FILL = 8'h80;
  localparam logic [7:0] LUMA_FILL   = 8'h00;

  function automatic logic is_low_power(input size_code_e code);
    return code[SIZE_W-1];
  endfunction
endpackage

// File: rtl/cam_line_ctr.sv
module cam_line_ctr #(
  parameter int LINE_CLKS = 1560,
  parameter int XW        = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [XW-1:0] h_pos,
  output logic          line_last
);
  localparam logic [XW-1:0] H_LAST = XW'(LINE_CLKS - 1);

  assign line_last = (h_pos == H_LAST);

  always_ff @(posedge clk) begin
    if (rst)            h_pos <= '0;
    else if (line_last) h_pos <= '0;
    else                h_pos <= h_pos + 1'b1;
  end
endmodule

// File: rtl/cam_frame_ctr.sv
module cam_frame_ctr
  import cam_sync_pkg::*;
#(
  parameter int LINES_NORM = 507,
  parameter int LINES_LP   = 254,
  parameter int VW         = $clog2(LINES_NORM > LINES_LP ? LINES_NORM : LINES_LP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_last,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_hs_blank,
  output logic [VW-1:0]     v_pos,
  output size_code_e        size_q,
  output logic              blank_q
);
  localparam logic [VW-1:0] V_LAST_NORM = VW'(LINES_NORM - 1);
  localparam logic [VW-1:0] V_LAST_LP   = VW'(LINES_LP - 1);

  logic [VW-1:0] v_last;
  logic          frame_last;

  always_comb begin
    v_last     = is_low_power(size_q) ? V_LAST_LP : V_LAST_NORM;
    frame_last = line_last && (v_pos == v_last);
  end

  // Configuration is shadowed and only refreshed at the frame seam.
  always_ff @(posedge clk) begin
    if (rst) begin
      v_pos   <= '0;
      size_q  <= size_code_e'(cfg_size);
      blank_q <= cfg_hs_blank;
    end else if (frame_last) begin
      v_pos   <= '0;
      size_q  <= size_code_e'(cfg_size);
      blank_q <= cfg_hs_blank;
    end else if (line_last) begin
      v_pos   <= v_pos + 1'b1;
    end
  end
endmodule

// File: rtl/cam_mask_ctr.sv
module cam_mask_ctr #(
  parameter int MASK_LINES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wake,
  input  logic line_last,
  input  logic line_active,
  output logic masked
);
  generate
    if (MASK_LINES == 0) begin : g_nomask
      assign masked = 1'b0;
    end else begin : g_mask
      localparam int MW = $clog2(MASK_LINES + 1);
      localparam logic [MW-1:0] RELOAD = MW'(MASK_LINES);
      logic [MW-1:0] remain;

      assign masked = (remain != '0);

      always_ff @(posedge clk) begin
        if (rst || wake)
          remain <= RELOAD;
        else if (line_last && line_active && masked)
          remain <= remain - 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/cam_sync_gen.sv
module cam_sync_gen
  import cam_sync_pkg::*;
#(
  parameter int LINE_CLKS  = 1560,
  parameter int HS_LOW     = 156,
  parameter int H_FIRST    = 280,
  parameter int LINES_NORM = 507,
  parameter int LINES_LP   = 254,
  parameter int VS_LINES   = 3,
  parameter int V_FIRST    = 9,
  parameter int MASK_LINES = 4,
  parameter int ACT_PIX   [NUM_SIZES] = '{640, 352, 320, 176, 320, 176, 160, 128},
  parameter int ACT_LINES [NUM_SIZES] = '{480, 288, 240, 144, 240, 144, 120, 96},
  parameter int XW = $clog2(LINE_CLKS),
  parameter int VW = $clog2(LINES_NORM > LINES_LP ? LINES_NORM : LINES_LP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_hs_blank,
  input  logic              wake,
  output logic              vsync,
  output logic              hsync,
  output logic              byte_en,
  output logic [7:0]        fill_byte,
  output logic              byte_sel,
  output logic [XW-1:0]     pix_x,
  output logic [VW-1:0]     line_y
);
  logic [XW-1:0] h_pos;
  logic          line_last;
  logic [VW-1:0] v_pos;
  size_code_e    size_q;
  logic          blank_q;
  logic          masked;

  cam_line_ctr #(.LINE_CLKS(LINE_CLKS), .XW(XW)) u_line (
    .clk(clk), .rst(rst), .h_pos(h_pos), .line_last(line_last)
  );

  cam_frame_ctr #(.LINES_NORM(LINES_NORM), .LINES_LP(LINES_LP), .VW(VW)) u_frame (
    .clk(clk), .rst(rst), .line_last(line_last),
    .cfg_size(cfg_size), .cfg_hs_blank(cfg_hs_blank),
    .v_pos(v_pos), .size_q(size_q), .blank_q(blank_q)
  );

  // Window decode against the shadowed picture size.
  logic [XW:0]   h_ext, h_end;
  logic [VW:0]   v_ext, v_end;
  logic          h_act, v_act, win, en_n;
  logic [XW-1:0] h_off;

  always_comb begin
    h_ext = {1'b0, h_pos};
    v_ext = {1'b0, v_pos};
    h_end = (XW+1)'(H_FIRST) + (XW+1)'(2 * ACT_PIX[size_q]);
    v_end = (VW+1)'(V_FIRST) + (VW+1)'(ACT_LINES[size_q]);
    h_act = (h_ext >= (XW+1)'(H_FIRST)) && (h_ext < h_end);
    v_act = (v_ext >= (VW+1)'(V_FIRST)) && (v_ext < v_end);
    win   = h_act && v_act;
    en_n  = win && !masked;
    h_off = h_pos - XW'(H_FIRST);
  end

  cam_mask_ctr #(.MASK_LINES(MASK_LINES)) u_mask (
    .clk(clk), .rst(rst), .wake(wake),
    .line_last(line_last), .line_active(v_act), .masked(masked)
  );

  // Registered output stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      vsync     <= 1'b1;
      hsync     <= 1'b0;
      byte_en   <= 1'b0;
      fill_byte <= CHROMA_FILL;
      byte_sel  <= 1'b0;
      pix_x     <= '0;
      line_y    <= '0;
    end else begin
      vsync     <= (v_pos >= VW'(VS_LINES));
      hsync     <= blank_q ? en_n : (h_pos >= XW'(HS_LOW));
      byte_en   <= en_n;
      fill_byte <= (en_n || h_pos[0]) ? LUMA_FILL : CHROMA_FILL;
      byte_sel  <= h_pos[0];
      pix_x     <= en_n ? {1'b0, h_off[XW-1:1]} : '0;
      line_y    <= v_act ? (v_pos - VW'(V_FIRST)) : '0;
    end
  end
endmodule

// File: rtl/cam_sync_gen_chk.sv
module cam_sync_gen_chk #(
  parameter int LINE_CLKS  = 1560,
  parameter int XW         = $clog2(LINE_CLKS),
  parameter int MASK_LINES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          wake,
  input logic [XW-1:0] h_pos,
  input logic          vsync,
  input logic          hsync,
  input logic          byte_en,
  input logic [7:0]    fill_byte,
  input logic          byte_sel,
  input logic [XW-1:0] pix_x
);
  localparam logic [XW-1:0] H_LAST = XW'(LINE_CLKS - 1);

  a_r1_line_wrap: assert property (@(posedge clk) disable iff (rst)
    (h_pos == H_LAST) |=> (h_pos == '0));

  a_r1_line_step: assert property (@(posedge clk) disable iff (rst)
    (h_pos != H_LAST) |=> (h_pos == $past(h_pos) + 1'b1));

  a_r4_en_under_hsync: assert property (@(posedge clk) disable iff (rst)
    byte_en |-> hsync);

  a_r2_en_outside_vsync: assert property (@(posedge clk) disable iff (rst)
    byte_en |-> vsync);

  a_r6_fill_value: assert property (@(posedge clk) disable iff (rst)
    !byte_en |-> (fill_byte == (byte_sel ? 8'h00 : 8'h80)));

  a_r7_burst_start: assert property (@(posedge clk) disable iff (rst)
    $rose(byte_en) |-> (pix_x == '0 && !byte_sel));

  a_r7_pixel_step: assert property (@(posedge clk) disable iff (rst)
    (byte_en && $past(byte_en) && !byte_sel) |-> (pix_x == $past(pix_x) + 1'b1));

  generate
    if (MASK_LINES > 0) begin : g_wake_chk
      a_r9_wake_masks: assert property (@(posedge clk) disable iff (rst)
        wake |=> ##1 !byte_en);
    end
  endgenerate
endmodule

bind cam_sync_gen cam_sync_gen_chk #(
  .LINE_CLKS(LINE_CLKS), .XW(XW), .MASK_LINES(MASK_LINES)
) u_chk (
  .clk(clk), .rst(rst), .wake(wake), .h_pos(h_pos),
  .vsync(vsync), .hsync(hsync), .byte_en(byte_en),
  .fill_byte(fill_byte), .byte_sel(byte_sel), .pix_x(pix_x)
);

// File: tb/cam_sync_gen_bench.sv
module cam_sync_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  localparam int LINE = 100;
  localparam int HSL  = 10;
  localparam int HF   = 12;
  localparam int LN   = 34;
  localparam int LP   = 18;
  localparam int VSL  = 1;
  localparam int VF   = 2;
  localparam int MSK  = 2;
  localparam int W_T [8] = '{40, 22, 20, 11, 20, 11, 10, 8};
  localparam int H_T [8] = '{30, 18, 15, 9, 15, 9, 8, 6};
  localparam int XWB = $clog2(LINE);
  localparam int VWB = $clog2(LN);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_size = 3'd0;
  logic cfg_blank = 1'b0;
  logic wake = 1'b0;
  logic vsync, hsync, byte_en, byte_sel;
  logic [7:0] fill_byte;
  logic [XWB-1:0] pix_x;
  logic [VWB-1:0] line_y;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_sync_gen #(
    .LINE_CLKS(LINE), .HS_LOW(HSL), .H_FIRST(HF), .LINES_NORM(LN), .LINES_LP(LP),
    .VS_LINES(VSL), .V_FIRST(VF), .MASK_LINES(MSK), .ACT_PIX(W_T), .ACT_LINES(H_T)
  ) u_cam_sync_gen (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_hs_blank(cfg_blank), .wake(wake),
    .vsync(vsync), .hsync(hsync), .byte_en(byte_en), .fill_byte(fill_byte),
    .byte_sel(byte_sel), .pix_x(pix_x), .line_y(line_y)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Position model built from the requirements.
  int m_h = 0, m_v = 0, m_sz = 0, m_mask = MSK;
  bit m_bl = 0, m_wk = 0;
  bit e_valid = 0, e_rst = 0;
  int e_vs, e_hs, e_en, e_fill, e_sel, e_x, e_y;
  string e_mtag = "R4";

  always @(posedge clk) begin
    if (rst) begin
      m_h = 0; m_v = 0; m_sz = int'(cfg_size); m_bl = cfg_blank; m_mask = MSK; m_wk = 0;
      e_vs = 1; e_hs = 0; e_en = 0; e_fill = 8'h80; e_sel = 0; e_x = 0; e_y = 0;
      e_rst = 1; e_valid = 1; e_mtag = "R4";
    end else begin
      int w2, hh, lines;
      bit vact, hact, win, en;
      w2 = 2 * W_T[m_sz];
      hh = H_T[m_sz];
      lines = (m_sz >= 4) ? LP : LN;
      vact = (m_v >= VF) && (m_v < VF + hh);
      hact = (m_h >= HF) && (m_h < HF + w2);
      win  = vact && hact;
      en   = win && (m_mask == 0);
      e_rst  = 0;
      e_vs   = (m_v >= VSL) ? 1 : 0;
      e_hs   = m_bl ? int'(en) : ((m_h >= HSL) ? 1 : 0);
      e_en   = int'(en);
      e_fill = (en || (m_h % 2 == 1)) ? 8'h00 : 8'h80;
      e_sel  = m_h % 2;
      e_x    = en ? (m_h - HF) / 2 : 0;
      e_y    = vact ? (m_v - VF) : 0;
      e_mtag = (win && m_mask != 0) ? (m_wk ? "R9" : "R8") : "R4";
      if (wake) begin
        m_mask = MSK; m_wk = 1;
      end else if (m_h == LINE - 1 && vact && m_mask > 0) begin
        m_mask--;
      end
      if (m_h == LINE - 1) begin
        m_h = 0;
        if (m_v == lines - 1) begin
          m_v = 0; m_sz = int'(cfg_size); m_bl = cfg_blank;
        end else begin
          m_v++;
        end
      end else begin
        m_h++;
      end
    end
  end

  // Cycle-by-cycle comparison, sampled away from the active edge.
  always @(negedge clk) begin
    if (e_valid) begin
      check(vsync == e_vs[0], e_rst ? "R11" : "R2", int'(vsync), e_vs);
      check(hsync == e_hs[0], e_rst ? "R11" : (m_bl ? "R5" : "R1"), int'(hsync), e_hs);
      check(byte_en == e_en[0], e_rst ? "R11" : e_mtag, int'(byte_en), e_en);
      check(int'(fill_byte) == e_fill, e_rst ? "R11" : "R6", int'(fill_byte), e_fill);
      check(int'(byte_sel) == e_sel, e_rst ? "R11" : "R7", int'(byte_sel), e_sel);
      check(int'(pix_x) == e_x, e_rst ? "R11" : "R7", int'(pix_x), e_x);
      check(int'(line_y) == e_y, e_rst ? "R11" : "R7", int'(line_y), e_y);
    end
  end

  task automatic wait_vs_fall();
    bit p;
    p = vsync;
    forever begin
      @(negedge clk);
      if (p && !vsync) break;
      p = vsync;
    end
  endtask

  // Counts one frame starting at the current (vsync-fall) negedge.
  task automatic measure(output int cyc, output int bytes, output int en_r, output int hs_r);
    bit pen, phs, pv;
    cyc = 1; bytes = int'(byte_en); en_r = 0; hs_r = 0;
    pen = byte_en; phs = hsync; pv = vsync;
    forever begin
      @(negedge clk);
      if (pv && !vsync) break;
      cyc++;
      if (byte_en) bytes++;
      if (byte_en && !pen) en_r++;
      if (hsync && !phs) hs_r++;
      pen = byte_en; phs = hsync; pv = vsync;
    end
  endtask

  task automatic t_reset_mask();
    int cyc, b, er, hr;
    rst = 1'b1; cfg_size = 3'd0; cfg_blank = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wait_vs_fall();
    measure(cyc, b, er, hr);
    check(cyc == LINE * LN, "R2", cyc, LINE * LN);
    check(b == 2 * W_T[0] * (H_T[0] - MSK), "R8", b, 2 * W_T[0] * (H_T[0] - MSK));
    check(er == H_T[0] - MSK, "R8", er, H_T[0] - MSK);
  endtask

  task automatic run_size(input int sz, input bit bl);
    int cyc, b, er, hr, lines;
    cfg_size = 3'(sz); cfg_blank = bl;
    wait_vs_fall();
    measure(cyc, b, er, hr);
    lines = (sz >= 4) ? LP : LN;
    check(cyc == LINE * lines, "R2", cyc, LINE * lines);
    check(b == 2 * W_T[sz] * H_T[sz], "R3", b, 2 * W_T[sz] * H_T[sz]);
    check(er == H_T[sz], "R3", er, H_T[sz]);
    if (bl) check(hr == H_T[sz], "R5", hr, H_T[sz]);
    else    check(hr == lines, "R1", hr, lines);
  endtask

  task automatic t_cfg_change();
    int cyc, b, er, hr;
    run_size(0, 1'b1);
    cfg_size = 3'd6; cfg_blank = 1'b0;
    measure(cyc, b, er, hr);
    check(cyc == LINE * LN, "R10", cyc, LINE * LN);
    check(b == 2 * W_T[0] * H_T[0], "R10", b, 2 * W_T[0] * H_T[0]);
    check(hr == H_T[0], "R10", hr, H_T[0]);
    measure(cyc, b, er, hr);
    check(cyc == LINE * LP, "R10", cyc, LINE * LP);
    check(b == 2 * W_T[6] * H_T[6], "R10", b, 2 * W_T[6] * H_T[6]);
    check(hr == LP, "R10", hr, LP);
  endtask

  task automatic t_wake();
    int cyc, b, er, hr;
    run_size(2, 1'b1);
    wake = 1'b1;
    fork
      begin
        @(negedge clk);
        wake = 1'b0;
      end
    join_none
    measure(cyc, b, er, hr);
    check(b == 2 * W_T[2] * (H_T[2] - MSK), "R9", b, 2 * W_T[2] * (H_T[2] - MSK));
    check(hr == H_T[2] - MSK, "R9", hr, H_T[2] - MSK);
  endtask

  initial begin
    t_reset_mask();
    for (int s = 0; s < 8; s++) run_size(s, s[0]);
    t_cfg_change();
    t_wake();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WD_CYCLES);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule